// File: doc/BRIEF.md
# Speculative Epoch Dependence Tracker

This block sits beside a shared second-level cache used by several CPU contexts that run ordered speculative epochs. For every line it keeps a read mark and a write mark per context. It checks, in the cycle a store is looked up, whether any logically later epoch has already read that line. Such readers have consumed a stale value. They are reported as violated, and all of their marks are wiped in the same step. A store is visible to later epochs at once, so a younger context that loads a line after an older context wrote it is not a violation.

Epoch order comes from a programmable rank per context. A lower rank is an older epoch, and rank 0 is the non-speculative epoch. A line may carry write marks from only one context. A store from a second context onto such a line is reported as a version conflict and is not performed, because keeping both versions is a different block's task. Commit and abort commands clear one context's marks in every line. A line with no marks left is free again. When a lookup misses and no line is free, the block raises `full` and the requester keeps its request.

Top module: `spec_dep_tracker`

## Requirements
- R1: After reset `viol`, `conflict` and `full` are 0, every line is free, and context i has rank i.
- R2: A load that misses takes a free line and sets the read mark of `req_ctx`. Loads of one tag by several contexts share one line.
- R3: A store accepted in cycle N by a context of rank r, to a line whose read mark is set for a context y with rank greater than r, makes `viol[y]` 1 in cycle N+1 only. Bit i of `viol` is context i.
- R4: A context whose rank is less than or equal to the storer's rank is never flagged, and neither is the storer itself. This includes a rank-0 context and a younger writer over an older reader.
- R5: At the edge that raises `viol[y]`, every read and write mark of context y is cleared, so its lines free up unless other marks remain.
- R6: A store onto a line that holds another context's write mark pulses `conflict` one cycle later. It sets no mark and flags no context.
- R7: `commit_valid` or `abort_valid` clears the named context's marks in every line. Both may arrive in the same cycle for different contexts.
- R8: In a cycle with a commit or abort, a valid request is not applied and `req_hold` is 1.
- R9: A missing request with no free line raises `full` and `req_hold` in that cycle and leaves all marks unchanged. The request is taken once a line is freed.
- R10: `rank_we` writes `rank_val` into the rank of `rank_ctx` at the clock edge. A request in the same cycle still uses the old ranks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load notification or store present |
| req_store | input | 1 | 1 = store, 0 = first load |
| req_ctx | input | CTX_W | Issuing context |
| req_tag | input | TAG_W | Line tag |
| req_hold | output | 1 | Request not taken this cycle; keep it |
| full | output | 1 | Miss with no free line |
| commit_valid | input | 1 | Commit a context |
| commit_ctx | input | CTX_W | Context to commit |
| abort_valid | input | 1 | Abort a context |
| abort_ctx | input | CTX_W | Context to abort |
| rank_we | input | 1 | Rank write enable |
| rank_ctx | input | CTX_W | Context whose rank is written |
| rank_val | input | RANK_W | New rank (lower is older) |
| viol | output | NCTX | Per-context violation pulse |
| conflict | output | 1 | Version conflict pulse |

## Verification
The embedded properties check the following on every cycle:
- No line ever carries write marks from two contexts.
- No two live lines share a tag.
- A flagged context has no marks left, and the storer is never flagged.
- A conflict pulse never coincides with a violation pulse.
- A commit leaves no marks of its context.
- A `full` cycle changes no state.

Which contexts are flagged under a given rank assignment can only be shown by the bench's scenarios. The same holds for lines freed by clearing becoming available to a held request, and for requests dropped during commit cycles. The bench covers these with directed cases and a long randomized sweep against an arithmetic reference.

// File: rtl/spec_dep_pkg.sv
// Shared types for the speculative dependence tracker.
package spec_dep_pkg;
    // Kind of access presented on the request port.
    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } req_kind_e;
endpackage

// File: rtl/sdt_rank_file.sv
// Per-context epoch rank registers.
// Compares each rank with the rank of the querying context.
// Assumes: lower rank = older epoch; reset rank of context i is i.
module sdt_rank_file #(
    parameter int NCTX   = 4,
    parameter int RANK_W = 3,
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [RANK_W-1:0] wr_rank,
    input  logic [CTX_W-1:0]  q_ctx,
    output logic [NCTX-1:0]   younger
);
    logic [NCTX-1:0][RANK_W-1:0] rank_q;

    // Rank storage with reset to context index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTX; i++) rank_q[i] <= RANK_W'(i);
        end else if (wr_en) begin
            rank_q[wr_ctx] <= wr_rank;
        end
    end

    // Mark every context strictly later in order than the querying one.
    always_comb begin
        for (int i = 0; i < NCTX; i++) younger[i] = (rank_q[i] > rank_q[q_ctx]);
    end
endmodule

// File: rtl/sdt_tag_match.sv
// Fully associative tag lookup and free-line pick.
// Assumes: a line is live exactly when it has any mark set.
module sdt_tag_match #(
    parameter int NLINES = 16,
    parameter int TAG_W  = 26
) (
    input  logic [NLINES-1:0][TAG_W-1:0] tags,
    input  logic [NLINES-1:0]            live,
    input  logic [TAG_W-1:0]             q_tag,
    output logic [NLINES-1:0]            hit_vec,
    output logic                         hit,
    output logic [NLINES-1:0]            free_vec,
    output logic                         free_avail
);
    // Compare the query tag against every live line.
    always_comb begin
        for (int i = 0; i < NLINES; i++) hit_vec[i] = live[i] && (tags[i] == q_tag);
        hit = |hit_vec;
    end

    // Select the lowest-indexed free line as a one-hot vector.
    always_comb begin
        free_vec   = '0;
        free_avail = 1'b0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_vec    = '0;
                free_vec[i] = 1'b1;
                free_avail  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdt_line_store.sv
// Line array: one tag plus a read mark and a write mark per context.
// Clearing by context mask is applied before the marks of the selected line are set.
// Assumes: the top never sets a mark for a context that it clears in the same cycle.
module sdt_line_store #(
    parameter int NLINES = 16,
    parameter int NCTX   = 4,
    parameter int TAG_W  = 26,
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NLINES-1:0]            line_we,
    input  logic                         set_rd,
    input  logic                         set_wr,
    input  logic [CTX_W-1:0]             wr_ctx,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [NCTX-1:0]              clear_mask,
    output logic [NLINES-1:0][TAG_W-1:0] tags,
    output logic [NLINES-1:0][NCTX-1:0]  rd_marks,
    output logic [NLINES-1:0][NCTX-1:0]  wr_marks,
    output logic [NLINES-1:0]            live
);
    logic [NCTX-1:0] ctx_bit;
    assign ctx_bit = NCTX'(1) << wr_ctx;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_r;
        logic [NCTX-1:0]  rd_r, wr_r, rd_n, wr_n;

        // Next marks: clear the masked contexts, then add the new mark.
        always_comb begin
            rd_n = rd_r & ~clear_mask;
            wr_n = wr_r & ~clear_mask;
            if (line_we[g]) begin
                if (set_rd) rd_n = rd_n | ctx_bit;
                if (set_wr) wr_n = wr_n | ctx_bit;
            end
        end

        // Mark and tag registers for one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r <= '0;
                rd_r  <= '0;
                wr_r  <= '0;
            end else begin
                rd_r <= rd_n;
                wr_r <= wr_n;
                if (line_we[g]) tag_r <= wr_tag;
            end
        end

        assign tags[g]     = tag_r;
        assign rd_marks[g] = rd_r;
        assign wr_marks[g] = wr_r;
        assign live[g]     = |(rd_r | wr_r);

        // A line never carries write marks from two contexts.
        assert_single_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(wr_r));

        for (genvar h = g + 1; h < NLINES; h++) begin : g_pair
            // Two live lines never hold the same tag.
            assert_unique_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (live[g] && live[h]) |-> (tags[g] != tags[h]));
        end
    end
endmodule

// File: rtl/spec_dep_tracker.sv
// Top of the speculative epoch dependence tracker.
// One request per cycle (load notification or store, tagged with a context).
// Commit and abort take the whole cycle, so a request in that cycle is held.
// Violation and conflict pulses are registered and appear one cycle after the store.
module spec_dep_tracker
    import spec_dep_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int NLINES = 16,
    parameter int TAG_W  = 26,
    parameter int RANK_W = 3,
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_hold,
    output logic              full,
    input  logic              commit_valid,
    input  logic [CTX_W-1:0]  commit_ctx,
    input  logic              abort_valid,
    input  logic [CTX_W-1:0]  abort_ctx,
    input  logic              rank_we,
    input  logic [CTX_W-1:0]  rank_ctx,
    input  logic [RANK_W-1:0] rank_val,
    output logic [NCTX-1:0]   viol,
    output logic              conflict
);
    logic [NLINES-1:0][TAG_W-1:0] tags_arr;
    logic [NLINES-1:0][NCTX-1:0]  rd_arr, wr_arr;
    logic [NLINES-1:0]            live, hit_vec, free_vec, line_we;
    logic                         hit, free_avail;
    logic [NCTX-1:0]              younger, sel_rd, sel_wr, ctx_bit, viol_now, clear_mask;
    logic                         cmd_active, accept, conflict_now, do_store, do_load;
    req_kind_e                    kind;

    assign kind    = req_kind_e'(req_store);
    assign ctx_bit = NCTX'(1) << req_ctx;

    sdt_rank_file #(.NCTX(NCTX), .RANK_W(RANK_W)) u_rank (
        .clk(clk), .rst_n(rst_n), .wr_en(rank_we), .wr_ctx(rank_ctx),
        .wr_rank(rank_val), .q_ctx(req_ctx), .younger(younger)
    );

    sdt_tag_match #(.NLINES(NLINES), .TAG_W(TAG_W)) u_match (
        .tags(tags_arr), .live(live), .q_tag(req_tag), .hit_vec(hit_vec),
        .hit(hit), .free_vec(free_vec), .free_avail(free_avail)
    );

    // Gather the marks of the hit line (zero on a miss).
    always_comb begin
        sel_rd = '0;
        sel_wr = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (hit_vec[i]) begin
                sel_rd = sel_rd | rd_arr[i];
                sel_wr = sel_wr | wr_arr[i];
            end
        end
    end

    // Request arbitration, conflict test and violation detection at lookup.
    always_comb begin
        cmd_active   = commit_valid || abort_valid;
        accept       = req_valid && !cmd_active && (hit || free_avail);
        full         = req_valid && !cmd_active && !hit && !free_avail;
        req_hold     = req_valid && !accept;
        conflict_now = accept && (kind == KIND_STORE) && |(sel_wr & ~ctx_bit);
        do_store     = accept && (kind == KIND_STORE) && !conflict_now;
        do_load      = accept && (kind == KIND_LOAD);
        viol_now     = do_store ? (sel_rd & younger & ~ctx_bit) : '0;
        clear_mask   = viol_now;
        if (commit_valid) clear_mask[commit_ctx] = 1'b1;
        if (abort_valid)  clear_mask[abort_ctx]  = 1'b1;
        line_we      = (do_load || do_store) ? (hit ? hit_vec : free_vec) : '0;
    end

    sdt_line_store #(.NLINES(NLINES), .NCTX(NCTX), .TAG_W(TAG_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .line_we(line_we), .set_rd(do_load),
        .set_wr(do_store), .wr_ctx(req_ctx), .wr_tag(req_tag),
        .clear_mask(clear_mask), .tags(tags_arr), .rd_marks(rd_arr),
        .wr_marks(wr_arr), .live(live)
    );

    // Registered violation and conflict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol     <= '0;
            conflict <= 1'b0;
        end else begin
            viol     <= viol_now;
            conflict <= conflict_now;
        end
    end

    // A conflicting store flags nobody.
    assert_conflict_no_viol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (viol == '0));

    // Violations only follow a store request.
    assert_viol_after_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (viol != '0) |-> $past(req_valid && req_store));

    // The storing context is never flagged.
    assert_storer_spared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (viol != '0) |-> !viol[$past(req_ctx)]);

    // A miss with no free line leaves every mark untouched.
    assert_full_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($stable(rd_arr) && $stable(wr_arr)));

    for (genvar g = 0; g < NLINES; g++) begin : g_chk
        // A flagged context holds no marks.
        assert_viol_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_arr[g] | wr_arr[g]) & viol) == '0);

        // A committed context holds no marks in the next cycle.
        assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            commit_valid |=> !(rd_arr[g][$past(commit_ctx)] || wr_arr[g][$past(commit_ctx)]));
    end
endmodule

// File: tb/spec_dep_tracker_bench.sv
module spec_dep_tracker_bench;
    localparam int NC = 4, NL = 4, TW = 8, RW = 3, CW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, req_valid, req_store, req_hold, full;
    logic [CW-1:0] req_ctx, commit_ctx, abort_ctx, rank_ctx;
    logic [TW-1:0] req_tag;
    logic          commit_valid, abort_valid, rank_we, conflict;
    logic [RW-1:0] rank_val;
    logic [NC-1:0] viol;

    spec_dep_tracker #(.NCTX(NC), .NLINES(NL), .TAG_W(TW), .RANK_W(RW)) u_spec_dep_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_ctx(req_ctx), .req_tag(req_tag), .req_hold(req_hold), .full(full),
        .commit_valid(commit_valid), .commit_ctx(commit_ctx), .abort_valid(abort_valid),
        .abort_ctx(abort_ctx), .rank_we(rank_we), .rank_ctx(rank_ctx), .rank_val(rank_val),
        .viol(viol), .conflict(conflict)
    );

    int n_tests = 0, n_fail = 0;
    logic [TW-1:0] m_tag [NL];
    logic [NC-1:0] m_rd [NL];
    logic [NC-1:0] m_wr [NL];
    logic [RW-1:0] m_rank [NC];

    task automatic check(input string lbl, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", lbl, got, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, check combinational then registered outputs.
    task automatic step(input string lbl, input logic rv, input logic st, input logic [CW-1:0] c,
                        input logic [TW-1:0] t, input logic cv, input logic [CW-1:0] cc,
                        input logic av, input logic [CW-1:0] ac, input logic rwe,
                        input logic [CW-1:0] rc, input logic [RW-1:0] rvv);
        int hit, fr;
        logic [NC-1:0] ev, clr, cbit;
        logic ec, ef, eh;
        req_valid = rv; req_store = st; req_ctx = c; req_tag = t;
        commit_valid = cv; commit_ctx = cc; abort_valid = av; abort_ctx = ac;
        rank_we = rwe; rank_ctx = rc; rank_val = rvv;
        ev = '0; clr = '0; ec = 0; ef = 0; eh = 0; cbit = '0; cbit[c] = 1'b1;
        if (cv || av) begin
            eh = rv;
            if (cv) clr[cc] = 1'b1;
            if (av) clr[ac] = 1'b1;
        end else if (rv) begin
            hit = -1;
            for (int i = 0; i < NL; i++)
                if (((m_rd[i] | m_wr[i]) != 0) && m_tag[i] == t) hit = i;
            if (hit < 0) begin
                fr = -1;
                for (int i = NL - 1; i >= 0; i--) if ((m_rd[i] | m_wr[i]) == 0) fr = i;
                if (fr < 0) begin ef = 1; eh = 1; end
                else begin
                    m_tag[fr] = t;
                    if (st) m_wr[fr] = m_wr[fr] | cbit; else m_rd[fr] = m_rd[fr] | cbit;
                end
            end else if (st) begin
                if ((m_wr[hit] & ~cbit) != 0) ec = 1;
                else begin
                    for (int y = 0; y < NC; y++)
                        if (y != int'(c) && m_rd[hit][y] && m_rank[y] > m_rank[c]) ev[y] = 1'b1;
                    m_wr[hit] = m_wr[hit] | cbit;
                    clr = ev;
                end
            end else m_rd[hit] = m_rd[hit] | cbit;
        end
        for (int i = 0; i < NL; i++) begin
            m_rd[i] = m_rd[i] & ~clr;
            m_wr[i] = m_wr[i] & ~clr;
        end
        if (rwe) m_rank[rc] = rvv;
        #1;
        check({lbl, " full"}, 32'(full), 32'(ef));
        check({lbl, " hold"}, 32'(req_hold), 32'(eh));
        @(posedge clk);
        @(negedge clk);
        check({lbl, " viol"}, 32'(viol), 32'(ev));
        check({lbl, " conflict"}, 32'(conflict), 32'(ec));
    endtask

    task automatic ld(input string l, input logic [CW-1:0] c, input logic [TW-1:0] t);
        step(l, 1, 0, c, t, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic sto(input string l, input logic [CW-1:0] c, input logic [TW-1:0] t);
        step(l, 1, 1, c, t, 0, 0, 0, 0, 0, 0, 0);
    endtask

    bit done = 0;
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_store = 0; req_ctx = 0; req_tag = 0;
        commit_valid = 0; commit_ctx = 0; abort_valid = 0; abort_ctx = 0;
        rank_we = 0; rank_ctx = 0; rank_val = 0;
        for (int i = 0; i < NL; i++) begin m_rd[i] = '0; m_wr[i] = '0; m_tag[i] = '0; end
        for (int i = 0; i < NC; i++) m_rank[i] = RW'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 reset viol", 32'(viol), 0);
        check("R1 reset conflict", 32'(conflict), 0);
        check("R1 reset full", 32'(full), 0);

        // R2 shared line, R3 older store kills younger readers, R4 storer spared.
        ld("R2 ld c1", 1, 10); ld("R2 ld c2", 2, 10); ld("R2 ld c3", 3, 10);
        sto("R3 st c0", 0, 10);
        // R5 readers already wiped: second store flags nobody.
        sto("R5 restore c0", 0, 10);
        // R6 second writer conflicts.
        sto("R6 st c1", 1, 10);
        // R4 younger writer over older reader.
        ld("R4 ld c2", 2, 20); sto("R4 st c3", 3, 20);
        sto("R6 st c1 t20", 1, 20);
        // R7 abort frees the write mark; ctx2 (rank 2) now killed by ctx1 (rank 1).
        step("R7 abort c3", 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0);
        sto("R7 st c1 t20", 1, 20);
        check("R3 explicit mask", 32'(viol), 32'h4);
        // R7 commit two contexts at once.
        step("R7 commit+abort", 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0);
        // R1 all lines free: four distinct tags fit, R9 fifth is full.
        for (int k = 1; k <= 4; k++) ld("R1 fill", 0, TW'(k));
        ld("R9 full", 0, 5);
        ld("R9 still full", 0, 5);
        ld("R2 share hit", 1, 1);
        // R8 request during commit is held.
        step("R8 hold in commit", 1, 0, 0, 5, 1, 0, 0, 0, 0, 0, 0);
        ld("R9 after free", 0, 5);
        step("R8 store held", 1, 1, 0, 1, 0, 0, 1, 2, 0, 0, 0);
        check("R8 no viol from held store", 32'(viol), 0);
        // R10 reorder: ctx3 oldest, ctx0 youngest.
        step("R10 rank c3", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 0);
        step("R10 rank c0", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 3);
        step("R10 clear", 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
        ld("R10 ld c0", 0, 7); sto("R10 st c3", 3, 7);
        check("R10 explicit", 32'(viol), 32'h1);

        // Randomized sweep against the reference model.
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 5)
                step("sweep R7", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     CW'($urandom_range(0, 3)), TW'($urandom_range(0, 5)), 1,
                     CW'($urandom_range(0, 3)), 0, 0, 0, 0, 0);
            else if (r < 9)
                step("sweep R7 R8", 1, 1'($urandom_range(0, 1)), CW'($urandom_range(0, 3)),
                     TW'($urandom_range(0, 5)), 0, 0, 1, CW'($urandom_range(0, 3)), 0, 0, 0);
            else if (r < 12)
                step("sweep R10", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     CW'($urandom_range(0, 3)), TW'($urandom_range(0, 5)), 0, 0, 0, 0, 1,
                     CW'($urandom_range(0, 3)), RW'($urandom_range(0, 7)));
            else
                step("sweep R3 R6 R9", 1, 1'($urandom_range(0, 1)), CW'($urandom_range(0, 3)),
                     TW'($urandom_range(0, 5)), 0, 0, 0, 0, 0, 0, 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule